// File: doc/BRIEF.md
# Programmable Chip Select Controller

This block sits beside the bus interface of a processor subsystem. It turns each bus transfer into a timed chip-select strobe for one of eight external regions, plus byte-lane write strobes. Software programs a base, a mask and a timing word for each region through a simple register write port. At the start of a transfer the block compares the address against every enabled region and picks one. It then runs a short sequence: an optional setup clock, the programmed wait clocks ending in an acknowledge pulse, and an optional hold clock. The hold clock is chosen separately for reads and for writes.

Two regions have extra duties. Region 0 answers every address from reset, so a boot memory can be fetched before software has moved it to its real base. That ends on the first write to region 0's base register. Region 1 also answers processor-space cycles such as interrupt acknowledges, whatever the address. A transfer that hits no region still gets an acknowledge, timed by a separate default timing word. The same decode serves transfers started by an external bus master, and for those the block also flags that it is driving the acknowledge.

Top module: `csel_ctrl`

## Requirements
- R1: While reset is applied and after it is released with no transfer, all `cs_n` and `we_n` bits are high and `xfer_ack` and `ack_oe` are low.
- R2: Region i matches when its enable bit is set and address bits [31:16] equal the base bits [31:16] in every position where mask bit is 0. Mask bits [30:16] set to 1 are ignored positions, and mask bit 31 is always compared, so sizes run from 64 KB to 2 GB. When several regions match, the lowest index wins.
- R3: After reset, region 0 matches every address, using region 0's timing word (reset value: BOOT_WAIT wait clocks, 32-bit port, no setup, no hold). Normal decoding of region 0 begins after the first write to its base register (`cfg_idx`=0, `cfg_reg`=0).
- R4: A transfer with `xfer_cpu_space` high asserts only `cs_n[1]`, whatever the address, and uses region 1's timing word.
- R5: With a wait count of N, the chip select is low for N+1 access clocks, and `xfer_ack` is high for exactly one clock, the last of them.
- R6: With the setup bit set, one clock with all chip selects high comes before the access clocks.
- R7: The hold bit for reads (control bit 7) and the hold bit for writes (control bit 8) each keep the chip select low for one clock after the acknowledge, for that direction only, with `we_n` high.
- R8: `we_n` bits go low only during the access clocks of a write. Lane i is data bits [8i+7:8i]. On a 32-bit port (port code 0), a byte selects lane addr[1:0], a half selects lanes 0-1 or 2-3 by addr[1], and a word selects all lanes. On a 16-bit port (code 2), a byte selects lane addr[0], and larger sizes select lanes 0-1. On an 8-bit port (code 1), every write selects lane 0. Size codes are 0 byte, 1 half, 2 word.
- R9: A transfer that matches no region asserts no chip select and acknowledges after the default timing word (`cfg_idx`=8), whose port code also selects the byte lanes.
- R10: For transfers started with `xfer_ext` high, `ack_oe` is high on every clock of the transfer sequence. It is low otherwise.
- R11: A start request that arrives while a transfer is in progress is ignored and does not alter the running sequence.
- R12: At most one chip select is low at any time.

Control word layout: bits [3:0] wait count, [5:4] port code, [6] setup, [7] read hold, [8] write hold, [9] region enable. Register selector `cfg_reg`: 0 base, 1 mask, 2 control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Region index 0-7, 8 for default timing |
| cfg_reg | input | 2 | Register select: 0 base, 1 mask, 2 control |
| cfg_wdata | input | 32 | Register write data |
| xfer_start | input | 1 | Transfer request, address valid |
| xfer_addr | input | 32 | Transfer address |
| xfer_write | input | 1 | 1 for write, 0 for read |
| xfer_size | input | 2 | 0 byte, 1 half, 2 word |
| xfer_cpu_space | input | 1 | Processor-space cycle |
| xfer_ext | input | 1 | Transfer started by an external master |
| cs_n | output | 8 | Active-low chip selects |
| we_n | output | 4 | Active-low byte write enables |
| xfer_ack | output | 1 | Transfer acknowledge pulse |
| ack_oe | output | 1 | Block is driving the acknowledge for an external master |

## Verification
On every clock, the assertions check several rules: no two chip selects are low together, write strobes appear only inside a write, the acknowledge is a single-clock pulse, and a miss never drives a chip select. They also check that a processor-space request lands on region 1 and that the selected region stays fixed while a sequence runs. The exact clock-by-clock shape of each sequence can only be shown by the directed scenarios. That shape includes setup, wait length, direction-dependent hold, byte-lane patterns per port width, the end of boot-wide decoding, mask boundaries and priority between overlapping regions.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;

  localparam int CSEL_WAIT_W = 4;
  localparam int CSEL_LANES  = 4;

  // Timing word; bit order is the software-visible control layout.
  typedef struct packed {
    logic                   enable;
    logic                   hold_wr;
    logic                   hold_rd;
    logic                   setup;
    logic [1:0]             port;
    logic [CSEL_WAIT_W-1:0] waits;
  } csel_ctrl_t;

  localparam int CSEL_CTRL_W = $bits(csel_ctrl_t);

  localparam logic [1:0] PORT_W32 = 2'd0;
  localparam logic [1:0] PORT_W8  = 2'd1;
  localparam logic [1:0] PORT_W16 = 2'd2;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;

  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2,
    PH_HOLD   = 2'd3
  } csel_phase_e;

endpackage

// File: rtl/csel_regs.sv
`timescale 1ns/1ps
module csel_regs
  import csel_pkg::*;
#(
  parameter int NUM_CS    = 8,
  parameter int ADDR_W    = 32,
  parameter int CMP_LSB   = 16,
  parameter int BOOT_WAIT = 4,
  localparam int IDX_W    = $clog2(NUM_CS + 1),
  localparam int CMP_W    = ADDR_W - CMP_LSB,
  localparam int MSK_W    = CMP_W - 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_wr,
  input  logic [IDX_W-1:0]                  cfg_idx,
  input  logic [1:0]                        cfg_reg,
  input  logic [ADDR_W-1:0]                 cfg_wdata,
  output logic [NUM_CS-1:0][CMP_W-1:0]      base_o,
  output logic [NUM_CS-1:0][MSK_W-1:0]      mask_o,
  output csel_ctrl_t [NUM_CS:0]             ctrl_o,
  output logic                              boot_o
);

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata[CMP_LSB-1:CSEL_CTRL_W];

  // Address registers for the decoded regions.
  for (genvar g = 0; g < NUM_CS; g++) begin : g_addr
    logic                 base_en, mask_en;
    logic [CMP_W-1:0]     base_q;
    logic [MSK_W-1:0]     mask_q;

    assign base_en = cfg_wr && (cfg_idx == IDX_W'(g)) && (cfg_reg == SEL_BASE);
    assign mask_en = cfg_wr && (cfg_idx == IDX_W'(g)) && (cfg_reg == SEL_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        mask_q <= '0;
      end else begin
        if (base_en) base_q <= cfg_wdata[ADDR_W-1:CMP_LSB];
        if (mask_en) mask_q <= cfg_wdata[ADDR_W-2:CMP_LSB];
      end
    end

    assign base_o[g] = base_q;
    assign mask_o[g] = mask_q;
  end

  // Timing words; index NUM_CS is the default (no-match) timing.
  for (genvar g = 0; g <= NUM_CS; g++) begin : g_ctrl
    localparam csel_ctrl_t CTRL_RST = (g == 0) ?
      csel_ctrl_t'({1'b0, 1'b0, 1'b0, 1'b0, PORT_W32, CSEL_WAIT_W'(BOOT_WAIT)}) :
      csel_ctrl_t'('0);
    logic       ctrl_en;
    csel_ctrl_t ctrl_q;

    assign ctrl_en = cfg_wr && (cfg_idx == IDX_W'(g)) && (cfg_reg == SEL_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= CTRL_RST;
      else if (ctrl_en) ctrl_q <= csel_ctrl_t'(cfg_wdata[CSEL_CTRL_W-1:0]);
    end

    assign ctrl_o[g] = ctrl_q;
  end

  // Boot-wide decode of region 0 until its base is first written.
  logic boot_q, boot_d;

  always_comb begin
    boot_d = boot_q;
    if (cfg_wr && (cfg_idx == '0) && (cfg_reg == SEL_BASE)) boot_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= boot_d;
  end

  assign boot_o = boot_q;

endmodule

// File: rtl/csel_match.sv
`timescale 1ns/1ps
module csel_match #(
  parameter int NUM_CS  = 8,
  parameter int CMP_W   = 16,
  localparam int IDX_W  = $clog2(NUM_CS + 1),
  localparam int MSK_W  = CMP_W - 1
) (
  input  logic [CMP_W-1:0]              addr_hi_i,
  input  logic                          cpu_space_i,
  input  logic                          boot_i,
  input  logic [NUM_CS-1:0][CMP_W-1:0]  base_i,
  input  logic [NUM_CS-1:0][MSK_W-1:0]  mask_i,
  input  logic [NUM_CS-1:0]             enable_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);

  logic [NUM_CS-1:0] region_hit;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    logic [CMP_W-1:0] care;
    logic             addr_eq;
    assign care    = ~{1'b0, mask_i[g]};
    assign addr_eq = ((addr_hi_i ^ base_i[g]) & care) == '0;
    if (g == 0) begin : g_boot
      assign region_hit[g] = boot_i || (enable_i[g] && addr_eq);
    end else begin : g_norm
      assign region_hit[g] = enable_i[g] && addr_eq;
    end
  end

  // Lowest index wins; processor-space cycles go to region 1.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (region_hit[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    if (cpu_space_i) begin
      hit_o = 1'b1;
      idx_o = IDX_W'(1);
    end
  end

endmodule

// File: rtl/csel_lanes.sv
`timescale 1ns/1ps
module csel_lanes
  import csel_pkg::*;
(
  input  logic [1:0]            addr_lo_i,
  input  logic [1:0]            size_i,
  input  logic [1:0]            port_i,
  output logic [CSEL_LANES-1:0] lanes_o
);

  always_comb begin
    lanes_o = '1;
    case (port_i)
      PORT_W8: begin
        lanes_o = 4'b0001;
      end
      PORT_W16: begin
        if (size_i == SIZE_BYTE) lanes_o = addr_lo_i[0] ? 4'b0010 : 4'b0001;
        else                     lanes_o = 4'b0011;
      end
      default: begin
        if (size_i == SIZE_BYTE)      lanes_o = 4'b0001 << addr_lo_i;
        else if (size_i == SIZE_HALF) lanes_o = addr_lo_i[1] ? 4'b1100 : 4'b0011;
        else                          lanes_o = 4'b1111;
      end
    endcase
  end

endmodule

// File: rtl/csel_seq.sv
`timescale 1ns/1ps
module csel_seq
  import csel_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int IDX_W = $clog2(NUM_CS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  write_i,
  input  logic                  ext_i,
  input  logic                  hit_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  csel_ctrl_t            ctrl_i,
  input  logic [CSEL_LANES-1:0] lanes_i,
  output logic                  busy_o,
  output logic                  cs_act_o,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      sel_o,
  output logic                  wr_o,
  output logic [CSEL_LANES-1:0] we_lanes_o,
  output logic                  ack_o,
  output logic                  ack_oe_o
);

  csel_phase_e             ph_q, ph_d;
  logic [CSEL_WAIT_W-1:0]  cnt_q, cnt_d;
  logic                    hit_q, hit_d;
  logic [IDX_W-1:0]        sel_q, sel_d;
  logic                    wr_q, wr_d;
  logic                    ext_q, ext_d;
  logic                    hold_q, hold_d;
  logic [CSEL_LANES-1:0]   lanes_q, lanes_d;
  logic                    cap_en;
  logic                    unused_en;

  assign unused_en = ctrl_i.enable;
  assign cap_en    = (ph_q == PH_IDLE) && start_i;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    hit_d   = hit_q;
    sel_d   = sel_q;
    wr_d    = wr_q;
    ext_d   = ext_q;
    hold_d  = hold_q;
    lanes_d = lanes_q;
    case (ph_q)
      PH_IDLE: begin
        if (cap_en) begin
          hit_d   = hit_i;
          sel_d   = idx_i;
          wr_d    = write_i;
          ext_d   = ext_i;
          hold_d  = write_i ? ctrl_i.hold_wr : ctrl_i.hold_rd;
          lanes_d = lanes_i;
          cnt_d   = ctrl_i.waits;
          ph_d    = ctrl_i.setup ? PH_SETUP : PH_ACCESS;
        end
      end
      PH_SETUP: begin
        ph_d = PH_ACCESS;
      end
      PH_ACCESS: begin
        if (cnt_q == '0) ph_d = hold_q ? PH_HOLD : PH_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: begin
        ph_d = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      hit_q   <= 1'b0;
      sel_q   <= '0;
      wr_q    <= 1'b0;
      ext_q   <= 1'b0;
      hold_q  <= 1'b0;
      lanes_q <= '0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      hit_q   <= hit_d;
      sel_q   <= sel_d;
      wr_q    <= wr_d;
      ext_q   <= ext_d;
      hold_q  <= hold_d;
      lanes_q <= lanes_d;
    end
  end

  assign busy_o     = (ph_q != PH_IDLE);
  assign cs_act_o   = hit_q && ((ph_q == PH_ACCESS) || (ph_q == PH_HOLD));
  assign hit_o      = hit_q;
  assign sel_o      = sel_q;
  assign wr_o       = wr_q;
  assign we_lanes_o = (wr_q && (ph_q == PH_ACCESS)) ? lanes_q : '0;
  assign ack_o      = (ph_q == PH_ACCESS) && (cnt_q == '0);
  assign ack_oe_o   = busy_o && ext_q;

endmodule

// File: rtl/csel_ctrl.sv
`timescale 1ns/1ps
module csel_ctrl
  import csel_pkg::*;
#(
  parameter int NUM_CS    = 8,
  parameter int ADDR_W    = 32,
  parameter int CMP_LSB   = 16,
  parameter int BOOT_WAIT = 4,
  localparam int IDX_W    = $clog2(NUM_CS + 1),
  localparam int CMP_W    = ADDR_W - CMP_LSB,
  localparam int MSK_W    = CMP_W - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [IDX_W-1:0]      cfg_idx,
  input  logic [1:0]            cfg_reg,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  input  logic                  xfer_start,
  input  logic [ADDR_W-1:0]     xfer_addr,
  input  logic                  xfer_write,
  input  logic [1:0]            xfer_size,
  input  logic                  xfer_cpu_space,
  input  logic                  xfer_ext,
  output logic [NUM_CS-1:0]     cs_n,
  output logic [CSEL_LANES-1:0] we_n,
  output logic                  xfer_ack,
  output logic                  ack_oe
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_ni = rst_pipe[1];

  logic [NUM_CS-1:0][CMP_W-1:0] base_all;
  logic [NUM_CS-1:0][MSK_W-1:0] mask_all;
  csel_ctrl_t [NUM_CS:0]        ctrl_all;
  logic                         boot_mode;
  logic [NUM_CS-1:0]            enable_all;
  logic                         dec_hit;
  logic [IDX_W-1:0]             dec_idx;
  csel_ctrl_t                   ctrl_sel;
  logic [CSEL_LANES-1:0]        lanes_dec;
  logic                         busy, cs_act, hit_q, wr_q, unused_misc;
  logic [IDX_W-1:0]             sel_q;
  logic [CSEL_LANES-1:0]        we_lanes;

  assign unused_misc = ^{xfer_addr[CMP_LSB-1:2], ctrl_all[NUM_CS].enable};

  csel_regs #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .CMP_LSB(CMP_LSB), .BOOT_WAIT(BOOT_WAIT)
  ) regs_i (
    .clk(clk), .rst_n(rst_ni), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .base_o(base_all),
    .mask_o(mask_all), .ctrl_o(ctrl_all), .boot_o(boot_mode)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_en
    assign enable_all[g] = ctrl_all[g].enable;
  end

  csel_match #(.NUM_CS(NUM_CS), .CMP_W(CMP_W)) match_i (
    .addr_hi_i(xfer_addr[ADDR_W-1:CMP_LSB]), .cpu_space_i(xfer_cpu_space),
    .boot_i(boot_mode), .base_i(base_all), .mask_i(mask_all),
    .enable_i(enable_all), .hit_o(dec_hit), .idx_o(dec_idx)
  );

  assign ctrl_sel = ctrl_all[dec_hit ? dec_idx : IDX_W'(NUM_CS)];

  csel_lanes lanes_i (
    .addr_lo_i(xfer_addr[1:0]), .size_i(xfer_size), .port_i(ctrl_sel.port),
    .lanes_o(lanes_dec)
  );

  csel_seq #(.NUM_CS(NUM_CS)) seq_i (
    .clk(clk), .rst_n(rst_ni), .start_i(xfer_start), .write_i(xfer_write),
    .ext_i(xfer_ext), .hit_i(dec_hit), .idx_i(dec_idx), .ctrl_i(ctrl_sel),
    .lanes_i(lanes_dec), .busy_o(busy), .cs_act_o(cs_act), .hit_o(hit_q),
    .sel_o(sel_q), .wr_o(wr_q), .we_lanes_o(we_lanes), .ack_o(xfer_ack),
    .ack_oe_o(ack_oe)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = ~(cs_act && (sel_q == IDX_W'(g)));
  end

  assign we_n = ~we_lanes;

endmodule

// File: rtl/csel_ctrl_chk.sv
`timescale 1ns/1ps
module csel_ctrl_chk #(
  parameter int NUM_CS = 8,
  parameter int IDX_W  = 4,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_start,
  input logic              xfer_cpu_space,
  input logic [NUM_CS-1:0] cs_n,
  input logic [LANES-1:0]  we_n,
  input logic              xfer_ack,
  input logic              busy,
  input logic              hit_q,
  input logic              wr_q,
  input logic [IDX_W-1:0]  sel_q
);

  // R12
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R8
  we_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n != '1) |-> (busy && wr_q));

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !xfer_ack);

  // R11
  sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(sel_q)));

  // R4
  cpu_space_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !busy && xfer_cpu_space) |=> (hit_q && sel_q == IDX_W'(1)));

  // R9
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hit_q) |-> (cs_n == '1));

endmodule

bind csel_ctrl csel_ctrl_chk #(.NUM_CS(NUM_CS), .IDX_W(IDX_W), .LANES(csel_pkg::CSEL_LANES)) chk_i (
  .clk(clk), .rst_n(rst_ni), .xfer_start(xfer_start),
  .xfer_cpu_space(xfer_cpu_space), .cs_n(cs_n), .we_n(we_n),
  .xfer_ack(xfer_ack), .busy(busy), .hit_q(hit_q), .wr_q(wr_q), .sel_q(sel_q)
);

// File: tb/csel_ctrl_tb_top.sv
`timescale 1ns/1ps
module csel_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [3:0]  cfg_idx;
  logic [1:0]  cfg_reg;
  logic [31:0] cfg_wdata;
  logic        xfer_start;
  logic [31:0] xfer_addr;
  logic        xfer_write;
  logic [1:0]  xfer_size;
  logic        xfer_cpu_space;
  logic        xfer_ext;
  logic [7:0]  cs_n;
  logic [3:0]  we_n;
  logic        xfer_ack;
  logic        ack_oe;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  csel_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .xfer_start(xfer_start),
    .xfer_addr(xfer_addr), .xfer_write(xfer_write), .xfer_size(xfer_size),
    .xfer_cpu_space(xfer_cpu_space), .xfer_ext(xfer_ext), .cs_n(cs_n),
    .we_n(we_n), .xfer_ack(xfer_ack), .ack_oe(ack_oe)
  );

  task automatic check(input string tag, input int k, input logic [13:0] got,
                       input logic [13:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s cycle %0d: {cs_n,we_n,ack,oe} got %b exp %b", tag, k, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] idx, input logic [1:0] sel,
                           input logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_reg = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Drive one transfer and compare every clock of its expected sequence.
  task automatic run_xfer(input string tag, input logic [31:0] addr,
                          input logic wr, input logic [1:0] size,
                          input logic cpu, input logic ext, input int exp_cs,
                          input bit setup, input int waits, input bit hold,
                          input logic [3:0] acc_we_n, input bit poke);
    int s, last, hk, total;
    logic acc, hld, act;
    logic [7:0] e_cs;
    logic [3:0] e_we;
    s     = setup ? 1 : 0;
    last  = s + waits;
    hk    = hold ? last + 1 : -1;
    total = last + 2 + (hold ? 1 : 0);
    @(negedge clk);
    xfer_start = 1'b1; xfer_addr = addr; xfer_write = wr; xfer_size = size;
    xfer_cpu_space = cpu; xfer_ext = ext;
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (poke && k == 0) begin
        xfer_start = 1'b1; xfer_addr = 32'hFFFF_0000; xfer_cpu_space = 1'b1;
        xfer_write = ~wr;
      end else begin
        xfer_start = 1'b0;
      end
      acc  = (k >= s) && (k <= last);
      hld  = (k == hk);
      act  = acc || hld;
      e_cs = (act && exp_cs >= 0) ? ~(8'd1 << exp_cs) : 8'hFF;
      e_we = (acc && wr) ? acc_we_n : 4'hF;
      check(tag, k, {cs_n, we_n, xfer_ack, ack_oe},
            {e_cs, e_we, acc && (k == last), ext && (k < total - 1)});
    end
    xfer_cpu_space = 1'b0; xfer_ext = 1'b0;
  endtask

  task automatic test_reset();
    // R1: idle outputs during and after reset
    check("R1 in reset", 0, {cs_n, we_n, xfer_ack, ack_oe}, {8'hFF, 4'hF, 1'b0, 1'b0});
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", 1, {cs_n, we_n, xfer_ack, ack_oe}, {8'hFF, 4'hF, 1'b0, 1'b0});
  endtask

  task automatic test_boot();
    // R3: region 0 answers everything with boot timing
    run_xfer("R3 boot read", 32'h1234_5678, 1'b0, 2'd2, 1'b0, 1'b0, 0, 0, 4, 0, 4'hF, 0);
    run_xfer("R3 R8 boot write", 32'hABCD_0000, 1'b1, 2'd2, 1'b0, 1'b0, 0, 0, 4, 0, 4'h0, 0);
    cfg_write(4'd1, 2'd0, 32'h2000_0000);
    cfg_write(4'd1, 2'd1, 32'h000F_0000);
    cfg_write(4'd1, 2'd2, 32'h0000_02E2);
    run_xfer("R3 boot overrides r1", 32'h2000_0000, 1'b0, 2'd2, 1'b0, 1'b0, 0, 0, 4, 0, 4'hF, 0);
  endtask

  task automatic test_relocate();
    cfg_write(4'd0, 2'd1, 32'h0000_0000);
    cfg_write(4'd0, 2'd2, 32'h0000_0201);
    cfg_write(4'd0, 2'd0, 32'h0000_0000);
    // R2 R6 R7: region 1 with setup, 2 waits, read hold
    run_xfer("R2 R6 R7 r1 read", 32'h2000_0004, 1'b0, 2'd2, 1'b0, 1'b0, 1, 1, 2, 1, 4'hF, 0);
    run_xfer("R3 R9 boot ended", 32'h1234_0000, 1'b0, 2'd2, 1'b0, 1'b0, -1, 0, 0, 0, 4'hF, 0);
    run_xfer("R2 64K top", 32'h0000_FFFC, 1'b0, 2'd2, 1'b0, 1'b0, 0, 0, 1, 0, 4'hF, 0);
    run_xfer("R2 64K beyond", 32'h0001_0000, 1'b0, 2'd2, 1'b0, 1'b0, -1, 0, 0, 0, 4'hF, 0);
  endtask

  task automatic test_priority();
    cfg_write(4'd2, 2'd0, 32'h2000_0000);
    cfg_write(4'd2, 2'd1, 32'h00FF_0000);
    cfg_write(4'd2, 2'd2, 32'h0000_0310);
    run_xfer("R2 R12 overlap low wins", 32'h2000_0000, 1'b0, 2'd2, 1'b0, 1'b0, 1, 1, 2, 1, 4'hF, 0);
    run_xfer("R7 R8 r2 byte write hold", 32'h2050_0003, 1'b1, 2'd0, 1'b0, 1'b0, 2, 0, 0, 1, 4'hE, 0);
    run_xfer("R7 r2 read no hold", 32'h2050_0003, 1'b0, 2'd0, 1'b0, 1'b0, 2, 0, 0, 0, 4'hF, 0);
    cfg_write(4'd3, 2'd0, 32'h3000_0000);
    cfg_write(4'd3, 2'd2, 32'h0000_0003);
    run_xfer("R2 disabled region", 32'h3000_0000, 1'b0, 2'd2, 1'b0, 1'b0, -1, 0, 0, 0, 4'hF, 0);
  endtask

  task automatic test_lanes();
    run_xfer("R8 p32 byte3", 32'h0000_0003, 1'b1, 2'd0, 1'b0, 1'b0, 0, 0, 1, 0, 4'b0111, 0);
    run_xfer("R8 p32 half hi", 32'h0000_0002, 1'b1, 2'd1, 1'b0, 1'b0, 0, 0, 1, 0, 4'b0011, 0);
    run_xfer("R8 p32 half lo", 32'h0000_0000, 1'b1, 2'd1, 1'b0, 1'b0, 0, 0, 1, 0, 4'b1100, 0);
    run_xfer("R8 R7 p16 half no wr hold", 32'h2000_0002, 1'b1, 2'd1, 1'b0, 1'b0, 1, 1, 2, 0, 4'b1100, 0);
    run_xfer("R8 p16 byte1", 32'h2000_0001, 1'b1, 2'd0, 1'b0, 1'b0, 1, 1, 2, 0, 4'b1101, 0);
  endtask

  task automatic test_default();
    cfg_write(4'd8, 2'd2, 32'h0000_0023);
    run_xfer("R9 default write", 32'h9000_0001, 1'b1, 2'd0, 1'b0, 1'b0, -1, 0, 3, 0, 4'b1101, 0);
  endtask

  task automatic test_cpu_space();
    run_xfer("R4 cpu unmapped", 32'h9000_0000, 1'b0, 2'd2, 1'b1, 1'b0, 1, 1, 2, 1, 4'hF, 0);
    run_xfer("R4 cpu over r0", 32'h0000_0000, 1'b0, 2'd2, 1'b1, 1'b0, 1, 1, 2, 1, 4'hF, 0);
  endtask

  task automatic test_external();
    run_xfer("R10 ext write", 32'h0000_0010, 1'b1, 2'd2, 1'b0, 1'b1, 0, 0, 1, 0, 4'h0, 0);
    run_xfer("R10 ext miss", 32'h7000_0000, 1'b0, 2'd2, 1'b0, 1'b1, -1, 0, 3, 0, 4'hF, 0);
  endtask

  task automatic test_busy();
    cfg_write(4'd0, 2'd2, 32'h0000_0205);
    // R5 R11: long wait, second start mid-sequence ignored
    run_xfer("R5 R11 busy ignore", 32'h0000_0020, 1'b0, 2'd2, 1'b0, 1'b0, 0, 0, 5, 0, 4'hF, 1);
    run_xfer("R5 after ignore", 32'h0000_0024, 1'b1, 2'd2, 1'b0, 1'b0, 0, 0, 5, 0, 4'h0, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_idx = '0; cfg_reg = '0; cfg_wdata = '0;
    xfer_start = 1'b0; xfer_addr = '0; xfer_write = 1'b0; xfer_size = '0;
    xfer_cpu_space = 1'b0; xfer_ext = 1'b0;
    repeat (3) @(negedge clk);
    test_reset();
    test_boot();
    test_relocate();
    test_priority();
    test_lanes();
    test_default();
    test_cpu_space();
    test_external();
    test_busy();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule